// File: doc/BRIEF.md
# Ready/Busy Status Pin Generator

This block produces the drive-low enable for an open-drain status pin that reports the activity of an embedded erase/program engine. A two-bit mode code picks what the pin means. In level mode the pin is pulled low for as long as the engine is working. In the three completion modes the pin gives a low pulse of fixed width when an erase finishes, when a program finishes, or when either finishes. When the engine is idle, suspended (the engine holds `busy` low while suspended) or in reset, the pin is released.

Each bank of the array keeps its own mode register. The mode registers clear to level mode on reset. A configuration write names the bank it targets. The bank that owns the current engine operation is given on `opBank`, and that bank's mode decides how the engine's events reach the pin. The pulse width is set in nanoseconds and turned into a cycle count from the clock period. A new completion event that arrives during a pulse restarts the pulse.

Top module: `stsPinGen`

## Requirements
- R1: While `rstN` is low, and in the cycle after it, every bank's mode is 00 and `driveLow` is 0.
- R2: Mode 00 (level) on the `opBank` bank: `driveLow` is 1 in each cycle after a clock edge at which `busy` was sampled high, and 0 one cycle after `busy` is sampled low. The busy indication therefore appears one clock (10 ns at 100 MHz) after the engine starts, well inside 500 ns. Done pulses have no effect in this mode.
- R3: Mode 01: an `eraseDone` pulse starts a low pulse. `progDone` and `busy` leave `driveLow` at 0.
- R4: Mode 10: a `progDone` pulse starts a low pulse. `eraseDone` and `busy` leave `driveLow` at 0.
- R5: Mode 11: either done pulse starts a low pulse. `busy` leaves `driveLow` at 0.
- R6: A low pulse lasts exactly ceil(PULSE_NS / CLK_PERIOD_NS) cycles, which is 25 cycles by default. It begins in the cycle after the edge that samples the done event.
- R7: A matching done event that arrives during a running pulse reloads the full width. The low time then ends a full pulse width after the second event.
- R8: A write with `cfgWrEn` high stores `cfgCode` only into bank `cfgBank`. The mode of bank b is shown on `bankCfg[2b+1:2b]`. Without a write, `bankCfg` keeps its value. Pin behaviour uses the mode of bank `opBank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWrEn | input | 1 | Mode write strobe |
| cfgBank | input | BANKW | Bank addressed by the mode write |
| cfgCode | input | 2 | Mode code to store |
| opBank | input | BANKW | Bank owning the current engine operation |
| busy | input | 1 | Engine is running an algorithm |
| eraseDone | input | 1 | One-cycle erase completion event |
| progDone | input | 1 | One-cycle program completion event |
| driveLow | output | 1 | Pull the status pin low; 0 means released |
| bankCfg | output | 2*NBANK | Mode codes of all banks, two bits per bank |

## Verification
Every pairing of the two banks' four codes is tried. For each pairing, both operating banks get an erase-done pulse, a program-done pulse and a busy window. The bench counts the low cycles and checks that the first low cycle follows the event. This separates the four modes from one another and shows whether the operating bank's mode, and not the other bank's, is used. Separate runs cover a second event during a pulse, where the low time must be longer than one width, and a reset during a pulse, which must release the pin and clear the modes.

// File: rtl/stsPkg.sv
package stsPkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_ANY   = 2'b11
  } stsMode_e;

  typedef struct packed {
    logic levelLow;   // hold pin low this cycle (level mode, busy)
    logic pulseLoad;  // (re)start completion pulse
  } stsStrobe_t;
endpackage

// File: rtl/stsCtrl.sv
module stsCtrl
  import stsPkg::*;
#(
  parameter int NBANK = 2,
  parameter int BANKW = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [BANKW-1:0]   cfgBank,
  input  logic [1:0]         cfgCode,
  input  logic [BANKW-1:0]   opBank,
  input  logic               busy,
  input  logic               eraseDone,
  input  logic               progDone,
  output stsStrobe_t         strobe,
  output logic [2*NBANK-1:0] bankCfg
);
  logic [1:0] selMode;

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    logic [1:0] modeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ <= MODE_LEVEL;
      end else if (cfgWrEn && (cfgBank == BANKW'(b))) begin
        modeQ <= cfgCode;
      end
    end
    assign bankCfg[2*b +: 2] = modeQ;
  end

  assign selMode = bankCfg[{opBank, 1'b0} +: 2];

  always_comb begin
    strobe.levelLow  = (selMode == MODE_LEVEL) && busy;
    strobe.pulseLoad = (selMode[0] && eraseDone) || (selMode[1] && progDone);
  end
endmodule

// File: rtl/stsDatapath.sv
module stsDatapath
  import stsPkg::*;
#(
  parameter int PULSE_CYC = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  stsStrobe_t strobe,
  output logic       driveLow
);
  localparam int CNTW = $clog2(PULSE_CYC + 1);

  logic [CNTW-1:0] pulseCnt;
  logic            levelQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      levelQ   <= 1'b0;
    end else begin
      levelQ <= strobe.levelLow;
      if (strobe.pulseLoad) begin
        pulseCnt <= CNTW'(PULSE_CYC);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  assign driveLow = levelQ || (pulseCnt != '0);
endmodule

// File: rtl/stsPinGen.sv
module stsPinGen
  import stsPkg::*;
#(
  parameter int NBANK         = 2,
  parameter int CLK_PERIOD_NS = 10,
  parameter int PULSE_NS      = 250,
  localparam int BANKW        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [BANKW-1:0]   cfgBank,
  input  logic [1:0]         cfgCode,
  input  logic [BANKW-1:0]   opBank,
  input  logic               busy,
  input  logic               eraseDone,
  input  logic               progDone,
  output logic               driveLow,
  output logic [2*NBANK-1:0] bankCfg
);
  localparam int PULSE_CYC = (PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  stsStrobe_t strobe;

  stsCtrl #(.NBANK(NBANK), .BANKW(BANKW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBank(cfgBank),
    .cfgCode(cfgCode), .opBank(opBank), .busy(busy),
    .eraseDone(eraseDone), .progDone(progDone),
    .strobe(strobe), .bankCfg(bankCfg)
  );

  stsDatapath #(.PULSE_CYC(PULSE_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .driveLow(driveLow)
  );
endmodule

// File: rtl/stsPinGenChk.sv
module stsPinGenChk #(
  parameter int NBANK = 2,
  parameter int BANKW = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [BANKW-1:0]   opBank,
  input logic               busy,
  input logic               eraseDone,
  input logic               progDone,
  input logic               driveLow,
  input logic [2*NBANK-1:0] bankCfg
);
  logic [1:0] mode;
  assign mode = bankCfg[{opBank, 1'b0} +: 2];

  AST_LEVEL_ASSERT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && busy) |=> driveLow);  // R2
  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !busy && !driveLow) |=> !driveLow);  // R2
  AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (mode[0] && eraseDone) |=> driveLow);  // R3
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && progDone) |=> driveLow);  // R4
  AST_ERASE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && !eraseDone && !driveLow) |=> !driveLow);  // R3
  AST_PROG_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && !progDone && !driveLow) |=> !driveLow);  // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(bankCfg));  // R8
endmodule

bind stsPinGen stsPinGenChk #(.NBANK(NBANK), .BANKW(BANKW)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .opBank(opBank), .busy(busy),
  .eraseDone(eraseDone), .progDone(progDone), .driveLow(driveLow),
  .bankCfg(bankCfg)
);

// File: tb/sim_stsPinGen.sv
module sim_stsPinGen;
  localparam int NBANK = 2;
  localparam int CLKNS = 10;
  localparam int PNS   = 250;
  localparam int PW    = (PNS + CLKNS - 1) / CLKNS;
  localparam int BUSYL = 7;
  localparam int WIN   = 45;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [0:0] cfgBank = '0;
  logic [1:0] cfgCode = '0;
  logic [0:0] opBank = '0;
  logic       busy = 1'b0;
  logic       eraseDone = 1'b0;
  logic       progDone = 1'b0;
  logic       driveLow;
  logic [3:0] bankCfg;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #(CLKNS/2) clk = ~clk;

  stsPinGen #(.NBANK(NBANK), .CLK_PERIOD_NS(CLKNS), .PULSE_NS(PNS)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBank(cfgBank),
    .cfgCode(cfgCode), .opBank(opBank), .busy(busy),
    .eraseDone(eraseDone), .progDone(progDone),
    .driveLow(driveLow), .bankCfg(bankCfg)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int bank, input int code);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgBank = 1'(bank); cfgCode = 2'(code);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // kind 0: erase done, 1: program done, 2: busy window
  // second > 0 repeats an erase done at that sample index
  task automatic runEvent(input int kind, input int second,
                          output int lowCnt, output int firstLow);
    @(negedge clk);
    eraseDone = (kind == 0);
    progDone  = (kind == 1);
    busy      = (kind == 2);
    lowCnt = 0; firstLow = 0;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge clk);
      if (driveLow) lowCnt++;
      if (i == 1) firstLow = int'(driveLow);
      if (i == 1) begin eraseDone = 1'b0; progDone = 1'b0; end
      if (i == BUSYL) busy = 1'b0;
      if (second > 0 && i == second) eraseDone = 1'b1;
      if (second > 0 && i == second + 1) eraseDone = 1'b0;
    end
  endtask

  function automatic int expLow(input int mode, input int kind);
    if (kind == 2) return (mode == 0) ? BUSYL : 0;
    if (kind == 0) return (mode % 2 == 1) ? PW : 0;
    return (mode >= 2) ? PW : 0;
  endfunction

  initial begin
    int lc, fl, e;
    repeat (3) @(negedge clk);
    check("R1 reset driveLow", int'(driveLow), 0);
    check("R1 reset bankCfg", int'(bankCfg), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset bankCfg", int'(bankCfg), 0);
    check("R1 after reset driveLow", int'(driveLow), 0);

    for (int c0 = 0; c0 < 4; c0++) begin
      for (int c1 = 0; c1 < 4; c1++) begin
        setCfg(0, c0);
        setCfg(1, c1);
        check("R8 bankCfg layout", int'(bankCfg), c1 * 4 + c0);
        for (int ob = 0; ob < 2; ob++) begin
          opBank = 1'(ob);
          for (int k = 0; k < 3; k++) begin
            e = expLow(ob == 0 ? c0 : c1, k);
            runEvent(k, 0, lc, fl);
            // R2 R3 R4 R5 R6: low time for mode/event pair
            check("R2/R3/R4/R5/R6 low cycles", lc, e);
            check("R6 first cycle after event", fl, (e > 0) ? 1 : 0);
          end
        end
      end
    end

    // R7: second erase event during the pulse restarts it
    setCfg(0, 1);
    opBank = 1'b0;
    runEvent(0, 10, lc, fl);
    check("R7 restart low cycles", lc, 10 + PW);
    setCfg(1, 3);
    opBank = 1'b1;
    runEvent(0, 20, lc, fl);
    check("R7 restart late", lc, 20 + PW);

    // R8: writing bank 1 leaves bank 0
    setCfg(0, 2);
    setCfg(1, 0);
    check("R8 bank0 kept", int'(bankCfg[1:0]), 2);
    check("R8 bank1 written", int'(bankCfg[3:2]), 0);

    // R1: reset during a pulse releases pin and clears modes
    opBank = 1'b0;
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
    check("R4 pulse running", int'(driveLow), 1);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-pulse driveLow", int'(driveLow), 0);
    check("R1 reset mid-pulse bankCfg", int'(bankCfg), 0);
    rstN = 1'b1;
    repeat (PW + 2) @(negedge clk);
    check("R1 stays released", int'(driveLow), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule